// File: doc/BRIEF.md
# Double-Stride Memory Prefetcher

This block watches demand requests, given as cache-line addresses, and follows up to eight independent access streams. Each stream is held in one table entry. The entry records the last line the stream touched, the most recent step (the first stride), the sum of the two most recent steps (the second stride) and a confidence count. The block handles plain constant steps such as +n,+n,+n. It also handles alternating pairs such as +n,+m,+n,+m. In both cases the second stride is the distance from the current line to the line two demands ahead.

When a demand lands near an existing stream, that entry folds the new step into its strides. It then checks whether the new step repeats the step taken two demands earlier, and raises or clears its confidence accordingly. Once the confidence reaches a configurable threshold, the block emits a prefetch line address two demands ahead through a valid/ready output stage. A demand that lands near no stream takes over the least recently used entry and clears it.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset every entry is empty and `pf_valid` is 0.
- R2: A demand whose line lies within ±MAX_STRIDE lines (default 4) of a tracked stream's last line updates that stream. The lowest-numbered entry wins if several qualify. Any other demand allocates an entry with last line set to the demand, both strides zero and count zero, and issues no prefetch.
- R3: On an update with step d = new line − last line (d ≠ 0): the second stride becomes d plus the old first stride, the first stride becomes d, and the last line becomes the demand line.
- R4: On an update, the count increments when d equals old second stride minus old first stride (the step two demands back). It saturates at 2^CNT_W−1 (default 7). Otherwise the count is cleared to 0.
- R5: When the count after an update is at least `conf_thresh`, a prefetch for demand line plus the new second stride appears on `pf_valid`/`pf_line` one clock after the demand is sampled.
- R6: Alternating two-step patterns and constant patterns, with positive or negative steps, both reach confidence and predict the line two demands ahead. Streams interleaved on the input are tracked independently.
- R7: A demand to exactly the last line of a stream (d = 0) leaves that stream's strides and count unchanged and issues no prefetch.
- R8: Replacement picks the entry least recently used by any demand, whether that demand allocated or updated. Entries never used are taken before any used one.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_line` hold. Prefetches produced in that time are discarded. With `pf_ready` 1 and nothing new, `pf_valid` drops on the next clock.
- R10: The threshold is a run-time input. A value of 0 issues on the first update of a stream, and a value of 7 issues only from the seventh confirmation onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_valid | input | 1 | Demand line address present this cycle |
| dmd_line | input | ADDR_W | Demand cache-line address |
| conf_thresh | input | CNT_W | Confidence needed before prefetches are issued |
| pf_ready | input | 1 | Downstream accepts the current prefetch |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | ADDR_W | Predicted cache-line address |

## Verification
The situation hardest to reach from the ports is replacement. The entry evicted is only visible through how much confidence a stream still has after other streams have come and gone. The bench fills all eight entries, refreshes the oldest stream, and opens a ninth stream. It then resumes two of the earlier streams and decides from whether a prefetch appears at the expected count which stream lost its history. Held-output backpressure and the same-line repeat are reached the same indirect way: a stream is walked to confidence first, and its later prefetch addresses show that nothing internal was disturbed.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // Classification of the demand seen in the current cycle.
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,  // no demand
    LK_NEW  = 2'd1,  // no stream nearby: allocate
    LK_STEP = 2'd2,  // nearby stream, nonzero step: update
    LK_SAME = 2'd3   // repeat of a stream's last line: no update
  } lookup_e;

endpackage

// File: rtl/spf_match.sv
module spf_match #(
  parameter int ADDR_W     = 32,
  parameter int NUM_ENT    = 8,
  parameter int MAX_STRIDE = 4,
  parameter int DLT_W      = 4,
  localparam int IDX_W     = $clog2(NUM_ENT)
) (
  input  logic [ADDR_W-1:0]               line_i,
  input  logic [NUM_ENT-1:0]              vld_i,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0]  last_i,
  output logic [NUM_ENT-1:0][DLT_W-1:0]   delta_o,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                hit_idx_o
);

  localparam logic [ADDR_W-1:0] WIN_POS = ADDR_W'(MAX_STRIDE);
  localparam logic [ADDR_W-1:0] WIN_NEG = ~WIN_POS + 1'b1;

  logic [NUM_ENT-1:0] near_w;

  // Distance test in two's complement: small positive or small negative.
  function automatic logic in_window(input logic [ADDR_W-1:0] diff);
    return (diff <= WIN_POS) || (diff >= WIN_NEG);
  endfunction

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [ADDR_W-1:0] diff_w;
    assign diff_w     = line_i - last_i[g];
    assign near_w[g]  = vld_i[g] && in_window(diff_w);
    assign delta_o[g] = diff_w[DLT_W-1:0];
  end

  // Lowest-numbered qualifying entry wins.
  always_comb begin
    hit_idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (near_w[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |near_w;

endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENT - 1);

  logic [NUM_ENT-1:0][IDX_W-1:0] age_q;
  logic [NUM_ENT-1:0]            vic_vec;
  logic [IDX_W-1:0]              touched_age;

  assign touched_age = age_q[touch_idx_i];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))      age_q[g] <= '0;
        else if (age_q[g] < touched_age)   age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign vic_vec[g] = (age_q[g] == OLDEST);
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (vic_vec[i]) victim_o = IDX_W'(i);
    end
  end

  // R8
  victim_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vic_vec) == 1);

endmodule

// File: rtl/spf_entry.sv
module spf_entry #(
  parameter int ADDR_W = 32,
  parameter int DLT_W  = 4,
  parameter int CNT_W  = 3,
  localparam int S2W   = DLT_W + 1,
  localparam int CW    = S2W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] line_i,
  input  logic [DLT_W-1:0]  delta_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] last_o,
  output logic [S2W-1:0]    nxt_s2_o,
  output logic [CNT_W-1:0]  nxt_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              vld_q;
  logic [ADDR_W-1:0] last_q;
  logic [DLT_W-1:0]  s1_q;
  logic [S2W-1:0]    s2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rep_w;

  // Second stride: new step plus previous step, sign-extended.
  function automatic logic [S2W-1:0] fold(input logic [DLT_W-1:0] d,
                                          input logic [DLT_W-1:0] s1);
    return {d[DLT_W-1], d} + {s1[DLT_W-1], s1};
  endfunction

  // Step two demands back is (second stride - first stride).
  function automatic logic repeats(input logic [DLT_W-1:0] d,
                                   input logic [DLT_W-1:0] s1,
                                   input logic [S2W-1:0]   s2);
    logic [CW-1:0] older;
    older = {s2[S2W-1], s2} - {{2{s1[DLT_W-1]}}, s1};
    return older == {{2{d[DLT_W-1]}}, d};
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c,
                                            input logic hit);
    if (!hit)          return '0;
    if (c == CNT_MAX)  return c;
    return c + 1'b1;
  endfunction

  assign rep_w     = repeats(delta_i, s1_q, s2_q);
  assign nxt_s2_o  = fold(delta_i, s1_q);
  assign nxt_cnt_o = bump(cnt_q, rep_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      cnt_q  <= '0;
    end else if (alloc_i) begin
      vld_q  <= 1'b1;
      last_q <= line_i;
      s1_q   <= '0;
      s2_q   <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      last_q <= line_i;
      s1_q   <= delta_i;
      s2_q   <= nxt_s2_o;
      cnt_q  <= nxt_cnt_o;
    end
  end

  assign vld_o  = vld_q;
  assign last_o = last_q;

  // R3
  stride_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (s1_q == $past(delta_i)) && (last_q == $past(line_i)));

  // R4
  conf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !rep_w) |=> (cnt_q == '0));

  // R4
  conf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && rep_w && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R2
  alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> vld_q && (cnt_q == '0) && (s1_q == '0) && (s2_q == '0));

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_valid_i,
  input  logic [ADDR_W-1:0] gen_line_i,
  input  logic              pf_ready_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_line_o
);

  logic load_w;
  assign load_w = !pf_valid_o || pf_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid_o <= 1'b0;
      pf_line_o  <= '0;
    end else if (load_w) begin
      pf_valid_o <= gen_valid_i;
      if (gen_valid_i) pf_line_o <= gen_line_i;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid_o && !pf_ready_i) |=> pf_valid_o && $stable(pf_line_o));

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int NUM_ENT    = 8,
  parameter int MAX_STRIDE = 4,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_line,
  input  logic [CNT_W-1:0]  conf_thresh,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_line
);
  import spf_pkg::*;

  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int DLT_W = $clog2(MAX_STRIDE + 1) + 1;
  localparam int S2W   = DLT_W + 1;

  logic [NUM_ENT-1:0]             vld_arr;
  logic [NUM_ENT-1:0][ADDR_W-1:0] last_arr;
  logic [NUM_ENT-1:0][DLT_W-1:0]  delta_arr;
  logic [NUM_ENT-1:0][S2W-1:0]    nxt_s2_arr;
  logic [NUM_ENT-1:0][CNT_W-1:0]  nxt_cnt_arr;

  logic             hit_w;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] touch_idx;
  lookup_e          lk_w;

  logic [S2W-1:0]    sel_s2;
  logic [CNT_W-1:0]  sel_cnt;
  logic              gen_valid;
  logic [ADDR_W-1:0] gen_line;

  spf_match #(
    .ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .MAX_STRIDE(MAX_STRIDE), .DLT_W(DLT_W)
  ) u_match (
    .line_i   (dmd_line),
    .vld_i    (vld_arr),
    .last_i   (last_arr),
    .delta_o  (delta_arr),
    .hit_o    (hit_w),
    .hit_idx_o(hit_idx)
  );

  always_comb begin
    if (!dmd_valid)                   lk_w = LK_NONE;
    else if (!hit_w)                  lk_w = LK_NEW;
    else if (delta_arr[hit_idx] == '0) lk_w = LK_SAME;
    else                              lk_w = LK_STEP;
  end

  assign touch_idx = hit_w ? hit_idx : victim_idx;

  spf_lru #(.NUM_ENT(NUM_ENT)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (dmd_valid),
    .touch_idx_i(touch_idx),
    .victim_o   (victim_idx)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic alloc_w, step_w;
    assign alloc_w = (lk_w == LK_NEW)  && (victim_idx == IDX_W'(g));
    assign step_w  = (lk_w == LK_STEP) && (hit_idx == IDX_W'(g));

    spf_entry #(.ADDR_W(ADDR_W), .DLT_W(DLT_W), .CNT_W(CNT_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (alloc_w),
      .step_i   (step_w),
      .line_i   (dmd_line),
      .delta_i  (delta_arr[g]),
      .vld_o    (vld_arr[g]),
      .last_o   (last_arr[g]),
      .nxt_s2_o (nxt_s2_arr[g]),
      .nxt_cnt_o(nxt_cnt_arr[g])
    );
  end

  // Target two demands ahead: demand line plus sign-extended second stride.
  function automatic logic [ADDR_W-1:0] ahead(input logic [ADDR_W-1:0] base,
                                              input logic [S2W-1:0]    s2);
    return base + {{(ADDR_W - S2W){s2[S2W-1]}}, s2};
  endfunction

  assign sel_s2    = nxt_s2_arr[hit_idx];
  assign sel_cnt   = nxt_cnt_arr[hit_idx];
  assign gen_valid = (lk_w == LK_STEP) && (sel_cnt >= conf_thresh);
  assign gen_line  = ahead(dmd_line, sel_s2);

  spf_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_valid_i(gen_valid),
    .gen_line_i (gen_line),
    .pf_ready_i (pf_ready),
    .pf_valid_o (pf_valid),
    .pf_line_o  (pf_line)
  );

  // R7
  same_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_w == LK_SAME) && (!pf_valid || pf_ready)) |=> !pf_valid);

  // R2
  alloc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_w == LK_NEW) |=> vld_arr[$past(victim_idx)]
                         && (last_arr[$past(victim_idx)] == $past(dmd_line)));

  // R5
  pf_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_valid && (!pf_valid || pf_ready)) |=> pf_valid);

endmodule

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 3;
  localparam int NV     = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dmd_valid = 1'b0;
  logic [ADDR_W-1:0] dmd_line = '0;
  logic [CNT_W-1:0]  conf_thresh = 3'd2;
  logic              pf_ready = 1'b1;
  logic              pf_valid;
  logic [ADDR_W-1:0] pf_line;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stride_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
    .conf_thresh(conf_thresh), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_line(pf_line)
  );

  // {demand line, expected pf_valid, expected pf_line}; threshold 2.
  // Streams: 0x100 step +2, 0x200 alternating +1/+3, 0x300 step -3.
  localparam logic [64:0] VEC [NV] = '{
    {32'h100, 1'b0, 32'h0},   {32'h200, 1'b0, 32'h0},
    {32'h102, 1'b0, 32'h0},   {32'h201, 1'b0, 32'h0},
    {32'h104, 1'b0, 32'h0},   {32'h204, 1'b0, 32'h0},
    {32'h106, 1'b0, 32'h0},   {32'h205, 1'b0, 32'h0},
    {32'h108, 1'b1, 32'h10C}, {32'h208, 1'b1, 32'h20C},
    {32'h300, 1'b0, 32'h0},   {32'h10A, 1'b1, 32'h10E},
    {32'h209, 1'b1, 32'h20D}, {32'h2FD, 1'b0, 32'h0},
    {32'h2FA, 1'b0, 32'h0},   {32'h2F7, 1'b0, 32'h0},
    {32'h2F4, 1'b1, 32'h2EE}, {32'h10B, 1'b0, 32'h0}
  };

  task automatic check(input string tag, input logic exp_v,
                       input logic [ADDR_W-1:0] exp_l);
    checks++;
    if (pf_valid !== exp_v || (exp_v && pf_line !== exp_l)) begin
      errors++;
      $display("FAIL %s: got valid=%0b line=%h, expected valid=%0b line=%h",
               tag, pf_valid, pf_line, exp_v, exp_l);
    end
  endtask

  task automatic do_reset();
    dmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Present one demand for one cycle; returns at the next falling edge,
  // when the registered prefetch output reflects it.
  task automatic demand(input logic [ADDR_W-1:0] a);
    dmd_valid = 1'b1;
    dmd_line  = a;
    @(negedge clk);
    dmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset quiet", 1'b0, '0);

    // R2 R3 R4 R5 R6: interleaved streams from the vector table
    for (int i = 0; i < NV; i++) begin
      demand(VEC[i][64:33]);
      check($sformatf("R6 vector %0d", i), VEC[i][32], VEC[i][31:0]);
    end

    // R7: repeat of the last line changes nothing
    do_reset();
    for (int k = 0; k <= 4; k++) demand(32'h400 + k);
    check("R5 confident stream", 1'b1, 32'h406);
    demand(32'h404);
    check("R7 same line no prefetch", 1'b0, '0);
    demand(32'h405);
    check("R7 strides and count kept", 1'b1, 32'h407);

    // R10: threshold 0
    do_reset();
    conf_thresh = 3'd0;
    demand(32'h500);
    check("R10 alloc never issues", 1'b0, '0);
    demand(32'h501);
    check("R10 threshold 0 first update", 1'b1, 32'h502);

    // R10 and R4 saturation: threshold 7
    do_reset();
    conf_thresh = 3'd7;
    for (int k = 0; k <= 8; k++) demand(32'h700 + k);
    check("R10 threshold 7 count 6", 1'b0, '0);
    demand(32'h709);
    check("R10 threshold 7 count 7", 1'b1, 32'h70B);
    demand(32'h70A);
    check("R4 count saturates", 1'b1, 32'h70C);

    // R8: least recently used replacement
    do_reset();
    conf_thresh = 3'd2;
    for (int k = 1; k <= 8; k++) demand(32'h1000 * k);
    demand(32'h1001);
    demand(32'h9000);
    demand(32'h1002);
    demand(32'h1003);
    demand(32'h1004);
    check("R8 refreshed stream survives", 1'b1, 32'h1006);
    demand(32'h2001);
    demand(32'h2002);
    demand(32'h2003);
    demand(32'h2004);
    check("R8 oldest stream evicted", 1'b0, '0);

    // R9: backpressure
    do_reset();
    pf_ready = 1'b0;
    for (int k = 0; k <= 4; k++) demand(32'h600 + k);
    check("R9 first prefetch", 1'b1, 32'h606);
    demand(32'h605);
    check("R9 held while stalled", 1'b1, 32'h606);
    pf_ready = 1'b1;
    @(negedge clk);
    check("R9 drops after accept", 1'b0, '0);
    demand(32'h606);
    check("R9 resumes after stall", 1'b1, 32'h608);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule